// File: doc/BRIEF.md
# DMA Channel User-Access Permission Checker

This block holds the user-mode permission state for a two-channel DMA engine and judges every coprocessor-style register access aimed at the DMA register group. Every channel has one enable bit. When a channel's bit is set, user-mode code may reach that channel's registers. When the bit is clear, the same access is refused with an undefined-instruction trap. Privileged code owns the permission register. It can always read and write that register, and it always reaches the channel registers.

An access arrives as a one-cycle strobe. The strobe carries a read/write flag, a privilege flag, a decoded register selector and write data. One clock later the block answers with exactly one of two pulses: grant or trap. A granted privileged read of the permission register returns the enable bits on the read-data bus in the same cycle as the grant. The channel registers and the channel-number register live elsewhere. This block only decides whether an access to them may proceed.

Top module: `dma_chan_guard`

## Requirements
- R1: After reset both channel enable bits are 0, and grant and trap are both low.
- R2: A privileged read of the permission register (selector 0) is granted, and its read data carries channel k's enable bit at bit k, with every higher bit 0.
- R3: A privileged write of the permission register stores write-data bits 1:0 as the enables for channels 1 and 0 and ignores bits 31:2. A later read returns bits 31:2 as 0.
- R4: Any user-mode read or write of the permission register traps, and a trapped write leaves the enable bits unchanged.
- R5: A user-mode access to a channel's registers (selector 2 for channel 0, selector 3 for channel 1) traps while that channel's enable bit is 0.
- R6: A user-mode access to a channel's registers is granted while that channel's enable bit is 1, whatever the other channel's bit holds.
- R7: A user-mode access to the channel-number register (selector 1) is granted when at least one enable bit is 1, and traps when both are 0.
- R8: Privileged accesses to the channel-number register and to either channel's registers are always granted, whatever the enable bits hold.
- R9: Grant or trap appears exactly one clock after the access strobe, and exactly one of them is asserted for each strobe. Neither is asserted in a cycle that follows no strobe.
- R10: Read data is 0 in every cycle except the cycle that answers a granted privileged read of the permission register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_priv | input | 1 | 1 = privileged mode, 0 = user mode |
| acc_sel | input | 2 | Register selector: 0 permission, 1 channel number, 2 channel 0, 3 channel 1 |
| acc_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid with the grant |
| acc_grant | output | 1 | Access granted, one cycle after the strobe |
| acc_trap | output | 1 | Undefined-instruction trap, one cycle after the strobe |

## Verification
The assertions check the response rules on every cycle: one response per strobe and none without one, user access to the permission register always trapping, user channel access tracking the matching enable bit, the channel-number rule, privileged channel access always being granted, the enable bits changing only after a privileged write, and the read-data bus staying zero outside a granted privileged read. Only the bench scenarios can show the values themselves. These are the exact read-back after writes with junk in the upper bits, the proof through a later read that a trapped user write changed nothing, and the full grant/trap matrix across all four enable combinations.

// File: rtl/dma_guard_pkg.sv
package dma_guard_pkg;
  localparam int SEL_PERM  = 0;
  localparam int SEL_CHNUM = 1;
  localparam int CHAN_BASE = 2;

  typedef struct packed {
    logic grant;
    logic trap;
    logic rd_perm;
  } verdict_t;
endpackage

// File: rtl/dma_perm_reg.sv
module dma_perm_reg #(
  parameter int NUM_CHAN = 2,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [NUM_CHAN-1:0] enables
);
  for (genvar k = 0; k < NUM_CHAN; k++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)        enables[k] <= 1'b0;
      else if (wr_en) enables[k] <= wr_data[k];
    end
  end

  // R3 / R4: enables change only after an allowed privileged write
  assert_enable_change_needs_write_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(enables) |-> $past(wr_en));
endmodule

// File: rtl/dma_access_judge.sv
module dma_access_judge
  import dma_guard_pkg::*;
#(
  parameter int NUM_CHAN = 2,
  parameter int SEL_W    = 2
) (
  input  logic                acc_valid,
  input  logic                acc_write,
  input  logic                acc_priv,
  input  logic [SEL_W-1:0]    acc_sel,
  input  logic [NUM_CHAN-1:0] enables,
  output verdict_t            verdict,
  output logic                perm_wr
);
  logic hit_perm, hit_chnum, hit_chan, chan_ok;

  always_comb begin
    hit_perm  = (acc_sel == SEL_W'(SEL_PERM));
    hit_chnum = (acc_sel == SEL_W'(SEL_CHNUM));
    hit_chan  = 1'b0;
    chan_ok   = 1'b0;
    for (int k = 0; k < NUM_CHAN; k++) begin
      if (acc_sel == SEL_W'(CHAN_BASE + k)) begin
        hit_chan = 1'b1;
        chan_ok  = enables[k];
      end
    end
  end

  always_comb begin
    verdict = '0;
    perm_wr = 1'b0;
    if (acc_valid) begin
      if (hit_perm) begin
        verdict.grant   = acc_priv;
        verdict.rd_perm = acc_priv && !acc_write;
        perm_wr         = acc_priv && acc_write;
      end else if (hit_chnum) begin
        verdict.grant = acc_priv || (|enables);
      end else if (hit_chan) begin
        verdict.grant = acc_priv || chan_ok;
      end
      verdict.trap = !verdict.grant;
    end
  end
endmodule

// File: rtl/dma_resp_stage.sv
module dma_resp_stage
  import dma_guard_pkg::*;
#(
  parameter int NUM_CHAN = 2,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  verdict_t            verdict,
  input  logic [NUM_CHAN-1:0] enables,
  output logic [DATA_W-1:0]   rd_data,
  output logic                grant,
  output logic                trap
);
  logic [DATA_W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    if (verdict.rd_perm) rd_next[NUM_CHAN-1:0] = enables;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant   <= 1'b0;
      trap    <= 1'b0;
      rd_data <= '0;
    end else begin
      grant   <= verdict.grant;
      trap    <= verdict.trap;
      rd_data <= rd_next;
    end
  end

  assert_single_response_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({grant, trap}));
  assert_upper_bits_zero_R10: assert property (@(posedge clk) disable iff (rst)
    rd_data[DATA_W-1:NUM_CHAN] == '0);
  assert_rdata_only_on_grant_R10: assert property (@(posedge clk) disable iff (rst)
    !grant |-> rd_data == '0);
endmodule

// File: rtl/dma_chan_guard.sv
module dma_chan_guard
  import dma_guard_pkg::*;
#(
  parameter int NUM_CHAN = 2,
  parameter int DATA_W   = 32,
  localparam int SEL_W   = $clog2(NUM_CHAN + CHAN_BASE)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic              acc_priv,
  input  logic [SEL_W-1:0]  acc_sel,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              acc_grant,
  output logic              acc_trap
);
  logic [NUM_CHAN-1:0] enables;
  verdict_t            verdict;
  logic                perm_wr;

  dma_perm_reg #(.NUM_CHAN(NUM_CHAN), .DATA_W(DATA_W)) u_perm (
    .clk(clk), .rst(rst), .wr_en(perm_wr), .wr_data(acc_wdata), .enables(enables));

  dma_access_judge #(.NUM_CHAN(NUM_CHAN), .SEL_W(SEL_W)) u_judge (
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_priv(acc_priv),
    .acc_sel(acc_sel), .enables(enables), .verdict(verdict), .perm_wr(perm_wr));

  dma_resp_stage #(.NUM_CHAN(NUM_CHAN), .DATA_W(DATA_W)) u_resp (
    .clk(clk), .rst(rst), .verdict(verdict), .enables(enables),
    .rd_data(rd_data), .grant(acc_grant), .trap(acc_trap));

  assert_strobe_gets_answer_R9: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> (acc_grant ^ acc_trap));
  assert_idle_no_answer_R9: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !(acc_grant || acc_trap));
  assert_user_perm_traps_R4: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_priv && acc_sel == SEL_W'(SEL_PERM)) |=> acc_trap);
  assert_user_ch0_follows_bit_R5: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_priv && acc_sel == SEL_W'(CHAN_BASE)) |=> (acc_grant == $past(enables[0])));
  assert_user_ch1_follows_bit_R6: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_priv && acc_sel == SEL_W'(CHAN_BASE + 1)) |=> (acc_grant == $past(enables[1])));
  assert_user_chnum_any_bit_R7: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_priv && acc_sel == SEL_W'(SEL_CHNUM)) |=> (acc_grant == $past(|enables)));
  assert_priv_chan_granted_R8: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_priv && acc_sel != SEL_W'(SEL_PERM)) |=> acc_grant);
endmodule

// File: tb/tb_dma_chan_guard.sv
module tb_dma_chan_guard;
  logic        clk = 1'b0;
  logic        rst;
  logic        acc_valid, acc_write, acc_priv;
  logic [1:0]  acc_sel;
  logic [31:0] acc_wdata;
  logic [31:0] rd_data;
  logic        acc_grant, acc_trap;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  dma_chan_guard dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one access; on return outputs of the response cycle are stable
  task automatic access(input logic wr, input logic pv, input logic [1:0] sel,
                        input logic [31:0] wd);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_priv = pv; acc_sel = sel; acc_wdata = wd;
    @(negedge clk);
    acc_valid = 1'b0; acc_wdata = 32'hDEAD_BEEF;
  endtask

  task automatic expect_resp(input string req, input logic g, input logic [31:0] rd);
    check(req, {30'b0, acc_grant, acc_trap}, {30'b0, g, !g});
    check(req, rd_data, rd);
  endtask

  task automatic set_enables(input logic [1:0] v);
    access(1'b1, 1'b1, 2'd0, {30'h3FFF_FFFF, v});
    expect_resp("R3 write", 1'b1, 32'h0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 grant", {31'b0, acc_grant}, 32'h0);
    check("R1 trap", {31'b0, acc_trap}, 32'h0);
    access(1'b0, 1'b1, 2'd0, 32'h0);
    expect_resp("R1 R2 read after reset", 1'b1, 32'h0);
  endtask

  task automatic t_priv_rw;
    access(1'b1, 1'b1, 2'd0, 32'hFFFF_FFFE);
    expect_resp("R3 write junk", 1'b1, 32'h0);
    access(1'b0, 1'b1, 2'd0, 32'h0);
    expect_resp("R2 R3 readback 2", 1'b1, 32'h2);
    access(1'b1, 1'b1, 2'd0, 32'h8000_0001);
    access(1'b0, 1'b1, 2'd0, 32'h0);
    expect_resp("R2 R3 readback 1", 1'b1, 32'h1);
  endtask

  task automatic t_user_perm;
    set_enables(2'b01);
    access(1'b0, 1'b0, 2'd0, 32'h0);
    expect_resp("R4 user read", 1'b0, 32'h0);
    access(1'b1, 1'b0, 2'd0, 32'h3);
    expect_resp("R4 user write", 1'b0, 32'h0);
    access(1'b0, 1'b1, 2'd0, 32'h0);
    expect_resp("R4 unchanged", 1'b1, 32'h1);
  endtask

  task automatic t_user_matrix;
    for (int v = 0; v < 4; v++) begin
      set_enables(v[1:0]);
      access(1'b0, 1'b0, 2'd2, 32'h0);
      expect_resp(v[0] ? "R6 ch0" : "R5 ch0", v[0], 32'h0);
      access(1'b1, 1'b0, 2'd3, 32'h0);
      expect_resp(v[1] ? "R6 ch1" : "R5 ch1", v[1], 32'h0);
      access(1'b0, 1'b0, 2'd1, 32'h0);
      expect_resp("R7 chnum", v != 0, 32'h0);
    end
  endtask

  task automatic t_priv_chan;
    set_enables(2'b00);
    for (int s = 1; s < 4; s++) begin
      access(s[0], 1'b1, s[1:0], 32'h0);
      expect_resp("R8 priv chan", 1'b1, 32'h0);
    end
  endtask

  task automatic t_timing;
    set_enables(2'b10);
    @(negedge clk);
    check("R9 idle grant", {31'b0, acc_grant}, 32'h0);
    check("R9 idle trap", {31'b0, acc_trap}, 32'h0);
    // back-to-back strobes: trap then grant on consecutive cycles
    @(negedge clk);
    acc_valid = 1; acc_write = 0; acc_priv = 0; acc_sel = 2'd2;
    @(negedge clk);
    expect_resp("R9 b2b first", 1'b0, 32'h0);
    acc_sel = 2'd3;
    @(negedge clk);
    expect_resp("R9 b2b second", 1'b1, 32'h0);
    acc_valid = 0;
    @(negedge clk);
    check("R9 R10 after", {30'b0, acc_grant, acc_trap}, 32'h0);
    check("R10 rd zero", rd_data, 32'h0);
  endtask

  initial begin
    rst = 1'b1; acc_valid = 0; acc_write = 0; acc_priv = 0; acc_sel = 0; acc_wdata = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_priv_rw();
    t_user_perm();
    t_user_matrix();
    t_priv_chan();
    t_timing();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule